// File: doc/BRIEF.md
# Cascaded Bit-Slice Magnitude Comparator

This block compares two unsigned operands of a parameterised width and raises exactly one of three results: greater, less or equal. It is built as a chain of one-bit comparison slices. The chain starts at the least significant bit, which receives a fixed "equal so far" seed. Each slice looks at one bit of each operand and the verdict passed up from the slice below it, then hands an updated verdict to the slice above. A slice whose two bits differ replaces the incoming verdict with its own. A slice whose two bits match passes the verdict up unchanged. The most significant slice therefore delivers the final answer.

A compile-time switch picks one of two slice types. The full slice carries an equal flag along the chain next to the greater and less flags. The reduced slice carries only greater and less. In that case the final equal result is a single NOR of the top slice's greater and less flags. Both types give the same results for every operand pair. The block is purely combinational and is used wherever a datapath needs an ordering decision between two unsigned words.

Top module: `mag_cmp_chain`

## Requirements
- R1: `gt_o` is 1 exactly when `a_i` is greater than `b_i`, with both read as unsigned numbers.
- R2: `lt_o` is 1 exactly when `a_i` is less than `b_i`, with both read as unsigned numbers.
- R3: `eq_o` is 1 exactly when `a_i` equals `b_i`. With both operands all zero, `eq_o` is 1 and the other two outputs are 0.
- R4: For every input, exactly one of `gt_o`, `lt_o`, `eq_o` is 1.
- R5: The most significant bit position where the operands differ decides the result. A 1 in `a_i` over a 0 in `b_i` there gives greater, whatever the lower bits hold. A 0 over a 1 gives less.
- R6: Bit positions where both operands hold the same value have no effect. Changing such a matching bit pair in both operands together, at a position above a differing bit, leaves the result unchanged.
- R7: The variant with the equal flag in every slice (`REDUCED`=0) and the variant that forms equal at the top (`REDUCED`=1) give identical outputs for the same operands.
- R8: The block works at the minimum width `WIDTH`=1, for all four operand pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First unsigned operand |
| b_i | input | WIDTH | Second unsigned operand |
| gt_o | output | 1 | High when a_i > b_i |
| lt_o | output | 1 | High when a_i < b_i |
| eq_o | output | 1 | High when a_i == b_i |

## Verification
The bench targets the following corner cases:
- Operand pairs that differ only in the top bit, with lower bits set against that top-bit verdict (for example 0x8000 against 0x7FFF). These catch a chain that lets a lower slice override a higher one, or that reads the result from the wrong end.
- Pairs that differ only in the least significant bit, with long runs of matching bits above it. These expose a slice that corrupts a verdict it should pass through unchanged.
- Equal operands, all zeros and all ones. These show a wrong seed or a faulty NOR in the reduced variant as a missing or doubled equal flag.
- The one-bit width, where one slice is both the first and the last.

Every vector is applied to both variants side by side. A difference between them is therefore reported even when both happen to agree with a wrong expectation.

// File: rtl/magcmp_pkg.sv
package magcmp_pkg;

  // Verdict passed from slice to slice; exactly one field is high.
  typedef struct packed {
    logic eq;
    logic gt;
    logic lt;
  } verdict_t;

  // Seed fed into the least significant slice: "equal so far".
  localparam verdict_t SEED = '{eq: 1'b1, gt: 1'b0, lt: 1'b0};

  // Full slice: a differing bit pair sets the verdict, a matching pair keeps it.
  function automatic verdict_t step_full(input logic abit, input logic bbit,
                                         input verdict_t below);
    verdict_t r;
    if (abit == bbit) begin
      r = below;
    end else begin
      r.eq = 1'b0;
      r.gt = abit;
      r.lt = bbit;
    end
    return r;
  endfunction

  // Reduced slice: only greater and less travel upward; eq is held at 0.
  function automatic verdict_t step_reduced(input logic abit, input logic bbit,
                                            input logic gt_below,
                                            input logic lt_below);
    verdict_t r;
    r.eq = 1'b0;
    r.gt = (abit & ~bbit) | (~(abit ^ bbit) & gt_below);
    r.lt = (~abit & bbit) | (~(abit ^ bbit) & lt_below);
    return r;
  endfunction

  // Equal is the absence of both orderings.
  function automatic logic eq_from_order(input logic gt, input logic lt);
    return ~(gt | lt);
  endfunction

endpackage

// File: rtl/cmp_slice_full.sv
module cmp_slice_full
  import magcmp_pkg::*;
(
  input  logic     abit_i,
  input  logic     bbit_i,
  input  verdict_t below_i,
  output verdict_t above_o
);
  assign above_o = step_full(abit_i, bbit_i, below_i);
endmodule

// File: rtl/cmp_slice_reduced.sv
module cmp_slice_reduced
  import magcmp_pkg::*;
(
  input  logic abit_i,
  input  logic bbit_i,
  input  logic gt_below_i,
  input  logic lt_below_i,
  output logic gt_above_o,
  output logic lt_above_o
);
  verdict_t step_w;
  assign step_w     = step_reduced(abit_i, bbit_i, gt_below_i, lt_below_i);
  assign gt_above_o = step_w.gt;
  assign lt_above_o = step_w.lt;
endmodule

// File: rtl/cmp_eq_merge.sv
module cmp_eq_merge
  import magcmp_pkg::*;
(
  input  logic gt_i,
  input  logic lt_i,
  output logic eq_o
);
  assign eq_o = eq_from_order(gt_i, lt_i);
endmodule

// File: rtl/mag_cmp_chain.sv
module mag_cmp_chain
  import magcmp_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter bit REDUCED = 1'b0
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             gt_o,
  output logic             lt_o,
  output logic             eq_o
);
  localparam int TOP = WIDTH;

  // link_w[i] is the verdict entering slice i; link_w[TOP] leaves the top slice.
  verdict_t [TOP:0] link_w;
  logic             top_eq_w;

  assign link_w[0] = SEED;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
      if (REDUCED) begin : g_red
        cmp_slice_reduced u_slice (
          .abit_i     (a_i[i]),
          .bbit_i     (b_i[i]),
          .gt_below_i (link_w[i].gt),
          .lt_below_i (link_w[i].lt),
          .gt_above_o (link_w[i+1].gt),
          .lt_above_o (link_w[i+1].lt)
        );
        assign link_w[i+1].eq = 1'b0;
      end else begin : g_full
        cmp_slice_full u_slice (
          .abit_i  (a_i[i]),
          .bbit_i  (b_i[i]),
          .below_i (link_w[i]),
          .above_o (link_w[i+1])
        );
      end
    end

    if (REDUCED) begin : g_eq_merge
      cmp_eq_merge u_merge (
        .gt_i (link_w[TOP].gt),
        .lt_i (link_w[TOP].lt),
        .eq_o (top_eq_w)
      );
    end else begin : g_eq_chain
      assign top_eq_w = link_w[TOP].eq;
    end
  endgenerate

  assign gt_o = link_w[TOP].gt;
  assign lt_o = link_w[TOP].lt;
  assign eq_o = top_eq_w;

endmodule

// File: rtl/mag_cmp_chain_chk.sv
module mag_cmp_chain_chk
  import magcmp_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter bit REDUCED = 1'b0
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             gt_o,
  input logic             lt_o,
  input logic             eq_o,
  input verdict_t [WIDTH:0] link_w
);
  always_comb begin
    assert_onehot_result_R4: assert ($countones({gt_o, lt_o, eq_o}) == 1)
      else $error("outputs not one-hot");
    assert_greater_R1: assert (gt_o == (a_i > b_i))
      else $error("gt_o disagrees with unsigned order");
    assert_less_R2: assert (lt_o == (a_i < b_i))
      else $error("lt_o disagrees with unsigned order");
    assert_equal_R3: assert (eq_o == (a_i == b_i))
      else $error("eq_o disagrees with operand equality");
    for (int i = 0; i < WIDTH; i++) begin
      // R6: a matching bit pair hands the order flags up unchanged.
      assert_pass_through_R6: assert ((a_i[i] != b_i[i]) ||
        ((link_w[i+1].gt == link_w[i].gt) && (link_w[i+1].lt == link_w[i].lt)))
        else $error("slice %0d altered a verdict on matching bits", i);
      // R5: a differing bit pair overrides whatever came from below.
      assert_override_R5: assert ((a_i[i] == b_i[i]) ||
        ((link_w[i+1].gt == a_i[i]) && (link_w[i+1].lt == b_i[i])))
        else $error("slice %0d did not override on differing bits", i);
    end
  end
endmodule

bind mag_cmp_chain mag_cmp_chain_chk #(.WIDTH(WIDTH), .REDUCED(REDUCED)) u_chk (
  .a_i    (a_i),
  .b_i    (b_i),
  .gt_o   (gt_o),
  .lt_o   (lt_o),
  .eq_o   (eq_o),
  .link_w (link_w)
);

// File: tb/mag_cmp_chain_bench.sv
module mag_cmp_chain_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [15:0] a16 = '0, b16 = '0;
  logic [3:0]  a4, b4;
  logic        a1, b1;
  assign a4 = a16[3:0];
  assign b4 = b16[3:0];
  assign a1 = a16[0];
  assign b1 = b16[0];

  logic f16_gt, f16_lt, f16_eq, r16_gt, r16_lt, r16_eq;
  logic f4_gt, f4_lt, f4_eq, r4_gt, r4_lt, r4_eq;
  logic f1_gt, f1_lt, f1_eq, r1_gt, r1_lt, r1_eq;

  mag_cmp_chain #(.WIDTH(16), .REDUCED(1'b0)) u_mag_cmp_chain (
    .a_i(a16), .b_i(b16), .gt_o(f16_gt), .lt_o(f16_lt), .eq_o(f16_eq));
  mag_cmp_chain #(.WIDTH(16), .REDUCED(1'b1)) u_mag_cmp_chain_r16 (
    .a_i(a16), .b_i(b16), .gt_o(r16_gt), .lt_o(r16_lt), .eq_o(r16_eq));
  mag_cmp_chain #(.WIDTH(4), .REDUCED(1'b0)) u_mag_cmp_chain_f4 (
    .a_i(a4), .b_i(b4), .gt_o(f4_gt), .lt_o(f4_lt), .eq_o(f4_eq));
  mag_cmp_chain #(.WIDTH(4), .REDUCED(1'b1)) u_mag_cmp_chain_r4 (
    .a_i(a4), .b_i(b4), .gt_o(r4_gt), .lt_o(r4_lt), .eq_o(r4_eq));
  mag_cmp_chain #(.WIDTH(1), .REDUCED(1'b0)) u_mag_cmp_chain_f1 (
    .a_i(a1), .b_i(b1), .gt_o(f1_gt), .lt_o(f1_lt), .eq_o(f1_eq));
  mag_cmp_chain #(.WIDTH(1), .REDUCED(1'b1)) u_mag_cmp_chain_r1 (
    .a_i(a1), .b_i(b1), .gt_o(r1_gt), .lt_o(r1_lt), .eq_o(r1_eq));

  typedef struct {
    logic [15:0] a;
    logic [15:0] b;
    logic [2:0]  exp16;   // {gt, lt, eq}
    logic [2:0]  exp4;
    logic [2:0]  exp1;
    string       tag;
  } item_t;

  item_t queue_q[$];
  int checks = 0;
  int errors = 0;

  // Reference: plain unsigned operators, bit order {gt, lt, eq}.
  function automatic logic [2:0] ref_order(input logic [15:0] x, input logic [15:0] y);
    return {x > y, x < y, x == y};
  endfunction

  task automatic drive(input logic [15:0] a, input logic [15:0] b, input string tag);
    item_t it;
    @(posedge clk);
    #1;
    a16 = a;
    b16 = b;
    it.a = a;
    it.b = b;
    it.exp16 = ref_order(a, b);
    it.exp4 = ref_order({12'd0, a[3:0]}, {12'd0, b[3:0]});
    it.exp1 = ref_order({15'd0, a[0]}, {15'd0, b[0]});
    it.tag = tag;
    queue_q.push_back(it);
  endtask

  task automatic check3(input logic [2:0] got, input logic [2:0] exp,
                        input string tag, input string who, input item_t it);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s a=%h b=%h actual={gt,lt,eq}=%b expected=%b",
               tag, who, it.a, it.b, got, exp);
    end
  endtask

  // Monitor: pops one item per cycle and compares every instance.
  always @(negedge clk) begin
    if (queue_q.size() > 0) begin
      item_t it;
      it = queue_q.pop_front();
      check3({f16_gt, f16_lt, f16_eq}, it.exp16, it.tag, "full16", it);
      check3({r16_gt, r16_lt, r16_eq}, it.exp16, it.tag, "reduced16", it);
      check3({f4_gt, f4_lt, f4_eq}, it.exp4, it.tag, "full4", it);
      check3({r4_gt, r4_lt, r4_eq}, it.exp4, it.tag, "reduced4", it);
      check3({f1_gt, f1_lt, f1_eq}, it.exp1, "R8 width1", "full1", it);
      check3({r1_gt, r1_lt, r1_eq}, it.exp1, "R8 width1", "reduced1", it);
      // R7: the two variants must agree with each other directly.
      check3({r16_gt, r16_lt, r16_eq}, {f16_gt, f16_lt, f16_eq}, "R7 variants", "r16_vs_f16", it);
      check3({r4_gt, r4_lt, r4_eq}, {f4_gt, f4_lt, f4_eq}, "R7 variants", "r4_vs_f4", it);
      // R4: exactly one output high.
      check3({2'b00, $countones({f16_gt, f16_lt, f16_eq}) == 1 &&
                     $countones({r16_gt, r16_lt, r16_eq}) == 1}, 3'b001,
             "R4 onehot", "16bit", it);
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired before all checks completed");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // R3: idle operands, all zero.
    drive(16'h0000, 16'h0000, "R3 reset zero");
    drive(16'hFFFF, 16'hFFFF, "R3 all ones");
    // R5: the top differing bit wins against lower bits.
    drive(16'h8000, 16'h7FFF, "R5 msb gt");
    drive(16'h7FFF, 16'h8000, "R5 msb lt");
    drive(16'h4008, 16'h3FF7, "R5 mid gt");
    // R6: matching upper bits pass the low verdict up.
    drive(16'hABC1, 16'hABC0, "R6 lsb gt");
    drive(16'h5430, 16'h5431, "R6 lsb lt");
    drive(16'hFFF1, 16'hFFF0, "R6 lsb gt high match");
    drive(16'h0001, 16'h0000, "R6 lsb gt low match");
    // R1 R2 R3: exhaustive over the low 4 bits, random upper bits.
    for (int i = 0; i < 256; i++) begin
      logic [15:0] ra, rb;
      ra = {$urandom_range(0, 4095) % 4096, 4'(i >> 4)};
      rb = {$urandom_range(0, 4095) % 4096, 4'(i)};
      if (i % 3 == 0) rb[15:4] = ra[15:4];
      drive({ra[15:4], 4'(i >> 4)}, {rb[15:4], 4'(i)}, "R1 R2 R3 exhaustive4");
    end
    // R1 R2 R3 R7: random 16-bit vectors, many near-equal.
    for (int k = 0; k < 2000; k++) begin
      logic [15:0] ra, rb;
      ra = 16'($urandom);
      case (k % 4)
        0: rb = ra;
        1: rb = ra ^ (16'd1 << (k % 16));
        default: rb = 16'($urandom);
      endcase
      drive(ra, rb, "R1 R2 R3 random16");
    end
    @(posedge clk);
    while (queue_q.size() > 0) @(posedge clk);
    @(posedge clk);
    finish_run();
  end

endmodule